// File: doc/BRIEF.md
# Configurable External Interrupt Controller

This block turns a small group of external input lines (up to four, typically general-purpose pins) into per-line interrupt requests. Each line is first passed through a two-stage synchroniser. A per-line detector then watches for the trigger condition chosen for that line: a rising edge, a falling edge, any edge, a high level or a low level. When the condition is seen, the line's pending status is set. That status is gated by the line's enable bit and is driven, through a register, onto that line's interrupt output.

All per-line controls sit in one 32-bit control word, which a simple write-strobe plus read-data port accesses. The word holds six fields. Field k holds the bit for line n at position n + k × FIELD_W. The field indices are: 0 polarity, 1 pending status (read-only), 2 clear, 3 enable, 4 any-edge, 5 level mode. Software takes a pending edge away by writing 1 to the line's clear bit.

A parameter selects a hold-clear variant. In that variant, a clear bit left at 1 keeps its line's output blocked and its edges ignored until software writes the bit back to 0.

Each line runs a three-state machine:
- LN_IDLE: nothing pending.
- LN_PEND: an edge is latched.
- LN_LEVEL: the level condition is present.

The transitions are:
- *edge_seen*: LN_IDLE or LN_LEVEL to LN_PEND, when an edge-mode line detects its edge.
- *cleared*: LN_PEND to LN_IDLE, on a clear pulse or while the hold-clear block is active.
- *level_on*: any state to LN_LEVEL, when a level-mode line's input matches its polarity.
- *level_off*: LN_LEVEL or LN_PEND to LN_IDLE, when a level-mode line's condition is absent.
- *mode_left*: LN_LEVEL to LN_IDLE, when the line leaves level mode.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every control word bit reads 0. This means every line is disabled and configured falling-edge, and every interrupt output is 0.
- R2: The bit for line n in field k is at position n + k × FIELD_W. The field indices are 0 polarity, 1 status, 2 clear, 3 enable, 4 any-edge and 5 level mode. Bits of lines beyond NUM_LINES, and bits at or above 6 × FIELD_W, read 0.
- R3: With level mode = 1, the status bit follows the synchronised input. It is 1 exactly while the input equals the polarity bit (1 = active high, 0 = active low).
- R4: With level mode = 0 and any-edge = 1, every transition of the input sets the status bit.
- R5: With level mode = 0 and any-edge = 0, the status bit is set by a rising edge when polarity = 1 and by a falling edge when polarity = 0. The opposite edge leaves it unchanged.
- R6: The interrupt output of a line is 1 only when, one cycle earlier, both its status bit and its enable bit were 1. With enable = 0 the status still records events.
- R7: Writing 1 to a clear bit removes a latched edge status on the clock edge of the write, unless a new edge arrives in that same cycle. On a level-mode line, a clear has no lasting effect while the level is present. The clear field reads back the last value written.
- R8: Writes to the status field have no effect on the status.
- R9: With HOLD_CLEAR = 1, while a line's clear bit is 1, its interrupt output is 0 and its edges are not latched. Once the bit is written back to 0, later edges are latched again.
- R10: An input change presented before clock edge e0 appears in the status at edge e2 and on the interrupt output at edge e3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_i | input | NUM_LINES | External input lines, asynchronous to clk |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read data, including live status |
| irq_o | output | NUM_LINES | Registered per-line interrupt outputs |

## Verification
The bench checks the exact two-cycle status latency and the three-cycle output latency of one edge. A design that dropped a synchroniser stage or left out the output register would show the status or the interrupt a cycle early.

Random trials cycle a line through all five trigger modes, including the opposite edge and no transition at all. A decoder that swapped the polarity sense, or let any-edge override level mode, produces a status mismatch.

Directed cases cover several behaviours:
- a masked line must still latch;
- a clear must not drop a level that is still present;
- status bits written from the bus must be ignored;
- in the hold-clear variant, an edge seen while the clear bit is held must not be remembered after release.

A second instance with a 5-bit stride exposes any design that hard-codes the field offsets.

// File: rtl/eic_pkg.sv
package eic_pkg;
    localparam int REG_W      = 32;
    localparam int NUM_FIELDS = 6;
    localparam int FLD_POL    = 0;
    localparam int FLD_STAT   = 1;
    localparam int FLD_CLR    = 2;
    localparam int FLD_EN     = 3;
    localparam int FLD_ANY    = 4;
    localparam int FLD_LVL    = 5;

    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_PEND  = 2'd1,
        LN_LEVEL = 2'd2
    } line_state_e;

    typedef struct packed {
        logic lvl;
        logic any;
        logic en;
        logic clr;
        logic pol;
    } line_cfg_t;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/eic_cfg_reg.sv
module eic_cfg_reg
    import eic_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int FIELD_W   = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [REG_W-1:0]                wdata,
    input  logic [NUM_LINES-1:0]            stat,
    output logic [REG_W-1:0]                rdata,
    output line_cfg_t [NUM_LINES-1:0]       cfg,
    output logic [NUM_LINES-1:0]            clr_pulse
);
    logic [NUM_LINES-1:0] pol_q, clr_q, en_q, any_q, lvl_q;
    logic                 unused_wdata;

    assign unused_wdata = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q <= '0;
            clr_q <= '0;
            en_q  <= '0;
            any_q <= '0;
            lvl_q <= '0;
        end else if (we) begin
            for (int n = 0; n < NUM_LINES; n++) begin
                pol_q[n] <= wdata[FLD_POL * FIELD_W + n];
                clr_q[n] <= wdata[FLD_CLR * FIELD_W + n];
                en_q[n]  <= wdata[FLD_EN  * FIELD_W + n];
                any_q[n] <= wdata[FLD_ANY * FIELD_W + n];
                lvl_q[n] <= wdata[FLD_LVL * FIELD_W + n];
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_cfg
            assign cfg[g].pol   = pol_q[g];
            assign cfg[g].clr   = clr_q[g];
            assign cfg[g].en    = en_q[g];
            assign cfg[g].any   = any_q[g];
            assign cfg[g].lvl   = lvl_q[g];
            assign clr_pulse[g] = we & wdata[FLD_CLR * FIELD_W + g];
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int n = 0; n < NUM_LINES; n++) begin
            rdata[FLD_POL  * FIELD_W + n] = pol_q[n];
            rdata[FLD_STAT * FIELD_W + n] = stat[n];
            rdata[FLD_CLR  * FIELD_W + n] = clr_q[n];
            rdata[FLD_EN   * FIELD_W + n] = en_q[n];
            rdata[FLD_ANY  * FIELD_W + n] = any_q[n];
            rdata[FLD_LVL  * FIELD_W + n] = lvl_q[n];
        end
    end
endmodule

// File: rtl/eic_line.sv
module eic_line
    import eic_pkg::*;
#(
    parameter int HOLD_CLEAR = 0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sync_in,
    input  line_cfg_t cfg,
    input  logic      clr_pulse,
    output logic      stat,
    output logic      edge_hit,
    output logic      irq
);
    line_state_e state, nxt;
    logic        prev;
    logic        rise, fall, lvl_hit, blk;
    logic        unused_cfg;

    assign unused_cfg = cfg.clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= sync_in;
    end

    assign rise     = sync_in & ~prev;
    assign fall     = ~sync_in & prev;
    assign edge_hit = cfg.any ? (rise | fall) : (cfg.pol ? rise : fall);
    assign lvl_hit  = (sync_in == cfg.pol);

    generate
        if (HOLD_CLEAR != 0) begin : g_hold
            assign blk = cfg.clr;
        end else begin : g_pulse
            assign blk = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LN_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            LN_IDLE: begin
                if (cfg.lvl)                 nxt = lvl_hit ? LN_LEVEL : LN_IDLE;
                else if (!blk && edge_hit)   nxt = LN_PEND;
            end
            LN_PEND: begin
                if (cfg.lvl)                 nxt = lvl_hit ? LN_LEVEL : LN_IDLE;
                else if (blk)                nxt = LN_IDLE;
                else if (edge_hit)           nxt = LN_PEND;
                else if (clr_pulse)          nxt = LN_IDLE;
            end
            LN_LEVEL: begin
                if (cfg.lvl)                 nxt = lvl_hit ? LN_LEVEL : LN_IDLE;
                else if (!blk && edge_hit)   nxt = LN_PEND;
                else                         nxt = LN_IDLE;
            end
            default:                         nxt = LN_IDLE;
        endcase
    end

    assign stat = (state != LN_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= stat & cfg.en & ~blk;
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import eic_pkg::*;
#(
    parameter int NUM_LINES  = 4,
    parameter int FIELD_W    = 4,
    parameter int HOLD_CLEAR = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] ext_i,
    input  logic                 cfg_we,
    input  logic [REG_W-1:0]     cfg_wdata,
    output logic [REG_W-1:0]     cfg_rdata,
    output logic [NUM_LINES-1:0] irq_o
);
    logic [NUM_LINES-1:0]      sync_v;
    logic [NUM_LINES-1:0]      line_stat;
    logic [NUM_LINES-1:0]      edge_hit;
    logic [NUM_LINES-1:0]      clr_pulse;
    line_cfg_t [NUM_LINES-1:0] cfg;

    eic_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ext_i),
        .q     (sync_v)
    );

    eic_cfg_reg #(.NUM_LINES(NUM_LINES), .FIELD_W(FIELD_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .wdata     (cfg_wdata),
        .stat      (line_stat),
        .rdata     (cfg_rdata),
        .cfg       (cfg),
        .clr_pulse (clr_pulse)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_line
            eic_line #(.HOLD_CLEAR(HOLD_CLEAR)) u_line (
                .clk       (clk),
                .rst_n     (rst_n),
                .sync_in   (sync_v[g]),
                .cfg       (cfg[g]),
                .clr_pulse (clr_pulse[g]),
                .stat      (line_stat[g]),
                .edge_hit  (edge_hit[g]),
                .irq       (irq_o[g])
            );
        end
    endgenerate
endmodule

// File: rtl/eic_checker.sv
module eic_checker
    import eic_pkg::*;
#(
    parameter int NUM_LINES  = 4,
    parameter int FIELD_W    = 4,
    parameter int HOLD_CLEAR = 0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [REG_W-1:0]     cfg_rdata,
    input logic [NUM_LINES-1:0] irq_o,
    input logic [NUM_LINES-1:0] line_stat,
    input logic [NUM_LINES-1:0] edge_hit,
    input logic [NUM_LINES-1:0] sync_v,
    input logic [NUM_LINES-1:0] clr_pulse
);
    localparam int USED = NUM_FIELDS * FIELD_W;

    // R2
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (USED >= REG_W) || ((cfg_rdata >> USED) == '0));

    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_chk
            // R6
            irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
                irq_o[g] |-> ($past(line_stat[g]) && $past(cfg_rdata[FLD_EN * FIELD_W + g])));

            // R7
            clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_pulse[g] && !edge_hit[g] && !cfg_rdata[FLD_LVL * FIELD_W + g])
                |=> !line_stat[g]);

            // R3
            level_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_rdata[FLD_LVL * FIELD_W + g] && (sync_v[g] == cfg_rdata[FLD_POL * FIELD_W + g]))
                |=> line_stat[g]);

            // R3
            level_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_rdata[FLD_LVL * FIELD_W + g] && (sync_v[g] != cfg_rdata[FLD_POL * FIELD_W + g]))
                |=> !line_stat[g]);

            // R5
            edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!cfg_rdata[FLD_LVL * FIELD_W + g] && edge_hit[g] &&
                 !((HOLD_CLEAR != 0) && cfg_rdata[FLD_CLR * FIELD_W + g]))
                |=> line_stat[g]);

            if (HOLD_CLEAR != 0) begin : g_hold
                // R9
                hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    cfg_rdata[FLD_CLR * FIELD_W + g] |=> !irq_o[g]);
            end
        end
    endgenerate
endmodule

bind ext_irq_ctrl eic_checker #(
    .NUM_LINES  (NUM_LINES),
    .FIELD_W    (FIELD_W),
    .HOLD_CLEAR (HOLD_CLEAR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_rdata (cfg_rdata),
    .irq_o     (irq_o),
    .line_stat (line_stat),
    .edge_hit  (edge_hit),
    .sync_v    (sync_v),
    .clr_pulse (clr_pulse)
);

// File: tb/tb_ext_irq_ctrl.sv
`timescale 1ns/1ps
module tb_ext_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ext_a = '0;
    logic        we_a = 1'b0;
    logic [31:0] wdata_a = '0;
    logic [31:0] rdata_a;
    logic [3:0]  irq_a;
    logic [2:0]  ext_b = '0;
    logic        we_b = 1'b0;
    logic [31:0] wdata_b = '0;
    logic [31:0] rdata_b;
    logic [2:0]  irq_b;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ext_irq_ctrl #(.NUM_LINES(4), .FIELD_W(4), .HOLD_CLEAR(0)) dut (
        .clk(clk), .rst_n(rst_n), .ext_i(ext_a), .cfg_we(we_a),
        .cfg_wdata(wdata_a), .cfg_rdata(rdata_a), .irq_o(irq_a)
    );

    ext_irq_ctrl #(.NUM_LINES(3), .FIELD_W(5), .HOLD_CLEAR(1)) dut_hold (
        .clk(clk), .rst_n(rst_n), .ext_i(ext_b), .cfg_we(we_b),
        .cfg_wdata(wdata_b), .cfg_rdata(rdata_b), .irq_o(irq_b)
    );

    function automatic logic [31:0] fbit(int w, int k, int n);
        return 32'h1 << (k * w + n);
    endfunction

    function automatic logic [31:0] put_line(logic [31:0] word, int w, int n,
                                             logic pol, logic en, logic any, logic lvl);
        logic [31:0] r;
        r = word & ~(fbit(w, 0, n) | fbit(w, 3, n) | fbit(w, 4, n) | fbit(w, 5, n));
        if (pol) r |= fbit(w, 0, n);
        if (en)  r |= fbit(w, 3, n);
        if (any) r |= fbit(w, 4, n);
        if (lvl) r |= fbit(w, 5, n);
        return r;
    endfunction

    function automatic logic exp_status(logic lvl, logic any, logic pol, logic old_v, logic new_v);
        if (lvl)            return new_v == pol;
        if (old_v == new_v) return 1'b0;
        if (any)            return 1'b1;
        return pol ? new_v : old_v;
    endfunction

    function automatic logic [31:0] readable_mask(int w, int lines);
        logic [31:0] m = '0;
        for (int k = 0; k < 6; k++)
            if (k != 1)
                for (int n = 0; n < lines; n++) m |= fbit(w, k, n);
        return m;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_a(input logic [31:0] d);
        @(negedge clk); we_a = 1'b1; wdata_a = d;
        @(negedge clk); we_a = 1'b0;
    endtask

    task automatic wr_b(input logic [31:0] d);
        @(negedge clk); we_b = 1'b1; wdata_b = d;
        @(negedge clk); we_b = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] cfg_a;
        logic [31:0] cfgb;
        void'($urandom(32'd1729));

        cyc(3);
        chk(rdata_a, 32'h0, "R1 reset word A");
        chk({28'h0, irq_a}, 32'h0, "R1 reset irq A");
        chk(rdata_b, 32'h0, "R1 reset word B");
        rst_n = 1'b1;
        cyc(2);

        // R2 field layout and unused bits, both strides
        wr_a(32'hFFFF_FFFF); cyc(1);
        chk(rdata_a, readable_mask(4, 4), "R2 layout W=4");
        wr_a(32'h0);
        wr_b(32'hFFFF_FFFF); cyc(1);
        chk(rdata_b, readable_mask(5, 3), "R2 layout W=5");
        wr_b(32'h0); cyc(2);

        // R10 latency of one rising edge on line 3
        cfg_a = put_line(32'h0, 4, 3, 1'b1, 1'b1, 1'b0, 1'b0);
        wr_a(cfg_a); cyc(2);
        ext_a[3] = 1'b1;
        cyc(2);
        chk({31'h0, rdata_a[4 + 3]}, 32'h0, "R10 status not yet at e1");
        cyc(1);
        chk({31'h0, rdata_a[4 + 3]}, 32'h1, "R10 status at e2");
        chk({31'h0, irq_a[3]}, 32'h0, "R10 irq not yet at e2");
        cyc(1);
        chk({31'h0, irq_a[3]}, 32'h1, "R10 irq at e3");

        // R7 clear pulse and read-back
        wr_a(cfg_a | fbit(4, 2, 3));
        chk({31'h0, rdata_a[8 + 3]}, 32'h1, "R7 clear read-back");
        chk({31'h0, rdata_a[4 + 3]}, 32'h0, "R7 edge status cleared");
        cyc(1);
        chk({31'h0, irq_a[3]}, 32'h0, "R7 irq drops after clear");
        wr_a(cfg_a);
        chk({31'h0, rdata_a[8 + 3]}, 32'h0, "R7 clear read-back 0");

        // R8 status field is read-only
        wr_a(cfg_a | fbit(4, 1, 0) | fbit(4, 1, 3)); cyc(2);
        chk({30'h0, rdata_a[4 + 3], rdata_a[4 + 0]}, 32'h0, "R8 status write ignored");
        chk({31'h0, irq_a[3]}, 32'h0, "R8 no irq from status write");

        // R6 masked line still records, output follows enable
        cfg_a = put_line(cfg_a, 4, 1, 1'b1, 1'b0, 1'b0, 1'b0);
        wr_a(cfg_a);
        ext_a[1] = 1'b1; cyc(5);
        chk({31'h0, rdata_a[4 + 1]}, 32'h1, "R6 masked status recorded");
        chk({31'h0, irq_a[1]}, 32'h0, "R6 masked irq low");
        cfg_a = put_line(cfg_a, 4, 1, 1'b1, 1'b1, 1'b0, 1'b0);
        wr_a(cfg_a); cyc(1);
        chk({31'h0, irq_a[1]}, 32'h1, "R6 irq after enable");

        // R7 clear has no lasting effect on a present level
        cfg_a = put_line(cfg_a, 4, 2, 1'b1, 1'b1, 1'b0, 1'b1);
        wr_a(cfg_a);
        ext_a[2] = 1'b1; cyc(5);
        chk({31'h0, rdata_a[4 + 2]}, 32'h1, "R3 level high status");
        wr_a(cfg_a | fbit(4, 2, 2));
        wr_a(cfg_a); cyc(1);
        chk({31'h0, rdata_a[4 + 2]}, 32'h1, "R7 level survives clear");
        chk({31'h0, irq_a[2]}, 32'h1, "R7 level irq survives clear");

        // Random trials over all trigger modes
        for (int t = 0; t < 80; t++) begin
            int   ln;
            int   md;
            logic en, old_v, new_v, lvl, any, pol, e;
            string tag;
            ln    = $urandom_range(3, 0);
            md    = $urandom_range(4, 0);
            en    = 1'($urandom_range(1, 0));
            old_v = 1'($urandom_range(1, 0));
            new_v = ($urandom_range(3, 0) != 0) ? ~old_v : old_v;
            lvl = 1'b0; any = 1'b0; pol = 1'b0;
            case (md)
                0: begin pol = 1'b1; tag = "R5 rising"; end
                1: begin pol = 1'b0; tag = "R5 falling"; end
                2: begin any = 1'b1; pol = 1'($urandom_range(1, 0)); tag = "R4 any edge"; end
                3: begin lvl = 1'b1; pol = 1'b1; tag = "R3 level high"; end
                default: begin lvl = 1'b1; pol = 1'b0; tag = "R3 level low"; end
            endcase
            cfg_a = put_line(cfg_a, 4, ln, pol, en, any, lvl);
            ext_a[ln] = old_v;
            wr_a(cfg_a); cyc(5);
            wr_a(cfg_a | fbit(4, 2, ln));
            wr_a(cfg_a); cyc(2);
            chk({31'h0, rdata_a[4 + ln]}, {31'h0, lvl && (old_v == pol)}, "R7 status after clear");
            ext_a[ln] = new_v; cyc(5);
            e = exp_status(lvl, any, pol, old_v, new_v);
            chk({31'h0, rdata_a[4 + ln]}, {31'h0, e}, tag);
            chk({31'h0, irq_a[ln]}, {31'h0, e & en}, "R6 irq equals status and enable");
        end

        // R9 hold-clear variant on the W=5 instance
        cfgb = put_line(32'h0, 5, 1, 1'b1, 1'b1, 1'b0, 1'b0);
        wr_b(cfgb);
        wr_b(cfgb | fbit(5, 2, 1));
        ext_b[1] = 1'b1; cyc(6);
        chk({31'h0, irq_b[1]}, 32'h0, "R9 irq blocked while clear held");
        chk({31'h0, rdata_b[5 + 1]}, 32'h0, "R9 edge ignored while clear held");
        wr_b(cfgb); cyc(3);
        chk({31'h0, rdata_b[5 + 1]}, 32'h0, "R9 edge not remembered after release");
        chk({31'h0, rdata_b[10 + 1]}, 32'h0, "R9 clear read-back 0");
        ext_b[1] = 1'b0; cyc(4);
        ext_b[1] = 1'b1; cyc(5);
        chk({31'h0, irq_b[1]}, 32'h1, "R9 edges latch again after release");

        cfgb = put_line(cfgb, 5, 0, 1'b1, 1'b1, 1'b0, 1'b1);
        ext_b[0] = 1'b1;
        wr_b(cfgb | fbit(5, 2, 0)); cyc(4);
        chk({31'h0, rdata_b[5 + 0]}, 32'h1, "R9 level status while clear held");
        chk({31'h0, irq_b[0]}, 32'h0, "R9 level irq blocked while clear held");
        wr_b(cfgb); cyc(2);
        chk({31'h0, irq_b[0]}, 32'h1, "R9 level irq after release");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule